// File: doc/BRIEF.md
# Per-Lane Eye-Tracking Phase Controller

This block is the digital control for one received serial lane whose bit is sampled through a wrapping per-bit delay line. It owns four delay codes. Two of them are guard-band probes that sit on the two edges of the open eye: a leading-edge probe and a trailing-edge probe. The other two are a pair of data samplers. At any moment one sampler delivers data and the other stands by. Probe compare results, qualified by a strobe, nudge each probe one step at a time, so that each probe dithers on its own edge of the eye. The block then derives the eye width and the eye centre from the two probe codes.

The standby sampler walks one step per sample strobe toward the eye centre by the shorter way round the delay line. The data sampler's code is never moved while it carries data. The standby sampler can be reported, from outside, as matching the data sampler. Once it does so at the centre for a run of consecutive samples, the two samplers swap roles with one select update. This lets the lane follow slow clock and temperature drift without a break in the data. A per-lane reference-voltage code is trained in single-count steps inside a clamped range. Every code and the derived eye figures can be read through a small address-selected read port while tracking runs.

Top module: `eye_trk_lane`

## Requirements
- R1: While reset is asserted and after it is released, the block holds these values: leading probe 0, trailing probe 32, both sampler taps 16, data_sel 0, eye width 32 and reference code 15.
- R2: On a cycle with edge_valid high, the leading probe code steps +1 if setup_err is 1 and −1 if it is 0, and the trailing probe code steps −1 if hold_err is 1 and +1 if it is 0. Without edge_valid, neither probe code changes.
- R3: Every delay code is 6 bits wide and wraps modulo 64 in both directions: 0 − 1 gives 63 and 63 + 1 gives 0.
- R4: eye_width equals (trailing − leading) mod 64. The centre equals leading + floor(width/2), mod 64.
- R5: data_sel = 0 makes tap A the data sampler and tap B the standby; data_sel = 1 reverses this. The data sampler's tap never changes. On each sample_valid cycle the standby tap moves one step toward the centre: up if (centre − standby) mod 64 lies in 1..31, down if it lies in 32..63 (so a tie goes down), and it holds if it equals the centre.
- R6: A sample_valid cycle qualifies when alt_match is 1 and the standby tap equals the centre. data_sel toggles on the 8th consecutive qualifying sample_valid cycle. A sample_valid cycle that does not qualify restarts the run, and cycles without sample_valid neither count nor restart it.
- R7: The reference code changes only on cycles with vref_step high: +1 when vref_up is 1 and −1 when it is 0. It is clamped to the range 0..30.
- R8: rd_data shows the value selected by rd_addr: 0 leading probe, 1 trailing probe, 2 data sampler tap, 3 standby tap, 4 eye width, 5 centre, 6 reference code, 7 data_sel. The value is zero-extended to 6 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| edge_valid | input | 1 | Strobe qualifying both probe compare results |
| setup_err | input | 1 | Leading-edge probe disagrees with data |
| hold_err | input | 1 | Trailing-edge probe disagrees with data |
| sample_valid | input | 1 | Strobe for one unit-interval sample of the sampler pair |
| alt_match | input | 1 | Standby sampler output equals data sampler output |
| vref_step | input | 1 | Request one reference-code step |
| vref_up | input | 1 | Direction of the reference step (1 = up) |
| rd_addr | input | 3 | Read port select |
| setup_code | output | 6 | Leading-edge probe delay code |
| hold_code | output | 6 | Trailing-edge probe delay code |
| tap_a_code | output | 6 | Delay code of sampler A |
| tap_b_code | output | 6 | Delay code of sampler B |
| data_sel | output | 1 | 0: sampler A carries data, 1: sampler B carries data |
| vref_code | output | 5 | Reference-voltage code |
| eye_width | output | 6 | Eye width in delay steps |
| rd_data | output | 6 | Read port data |

## Verification
A probe stepping the wrong way appears on its code output one cycle after the strobe. It also shows at once in eye_width and in the centre, so the direction tests watch those counts. A sampler that steps the long way round, or ties the wrong way, leaves the standby tap off by two or more a cycle later. The bench checks this just after the tap crosses code 0 and at an exact half-line distance. A wrong run counter either swaps one sample early or late, or keeps counting across a broken run. The bench therefore looks at data_sel just before and just after the 8th qualifying sample, including runs split by idle cycles.

// File: rtl/eye_trk_pkg.sv
package eye_trk_pkg;

  typedef enum logic [2:0] {
    RD_SETUP  = 3'd0,
    RD_HOLD   = 3'd1,
    RD_FUNC   = 3'd2,
    RD_ALT    = 3'd3,
    RD_WIDTH  = 3'd4,
    RD_CENTRE = 3'd5,
    RD_VREF   = 3'd6,
    RD_SEL    = 3'd7
  } rd_sel_e;

endpackage

// File: rtl/eye_edge_probe.sv
module eye_edge_probe #(
  parameter int CODE_W   = 6,
  parameter bit LEADING  = 1'b1,
  parameter int RST_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              err,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic [CODE_W-1:0] code_nxt;
  logic              go_up;

  // leading probe moves inward (up) on error, trailing probe moves inward (down)
  assign go_up = (err == LEADING);

  always_comb begin
    code_nxt = code;
    if (upd) begin
      if (go_up) code_nxt = code + ONE;
      else       code_nxt = code - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= CODE_W'(RST_CODE);
    else if (upd) code <= code_nxt;
  end

  // R2
  probe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((code == $past(code) + ONE) || (code == $past(code) - ONE)));

  // R2
  probe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(code));

endmodule

// File: rtl/eye_tap_pingpong.sv
module eye_tap_pingpong #(
  parameter int CODE_W  = 6,
  parameter int MATCH_N = 8,
  parameter int RST_TAP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic              alt_match,
  input  logic [CODE_W-1:0] centre,
  output logic [CODE_W-1:0] tap_a,
  output logic [CODE_W-1:0] tap_b,
  output logic              sel,
  output logic [CODE_W-1:0] func_code,
  output logic [CODE_W-1:0] alt_code
);

  localparam int                CNT_W = $clog2(MATCH_N + 1);
  localparam logic [CODE_W-1:0] HALF  = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W-1:0] ONE   = CODE_W'(1);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(MATCH_N - 1);

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [CODE_W-1:0] diff, alt_nxt;
  logic              sel_nxt, qualify, swap;

  assign func_code = sel ? tap_b : tap_a;
  assign alt_code  = sel ? tap_a : tap_b;
  assign diff      = centre - alt_code;
  assign qualify   = alt_match && (diff == '0);
  assign swap      = sample_valid && qualify && (cnt == LAST);

  always_comb begin
    alt_nxt = alt_code;
    if (diff != '0) begin
      if (diff < HALF) alt_nxt = alt_code + ONE;
      else             alt_nxt = alt_code - ONE;
    end
  end

  always_comb begin
    cnt_nxt = cnt;
    sel_nxt = sel;
    if (sample_valid) begin
      if (!qualify)  cnt_nxt = '0;
      else if (swap) cnt_nxt = '0;
      else           cnt_nxt = cnt + CNT_W'(1);
      if (swap) sel_nxt = ~sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_a <= CODE_W'(RST_TAP);
      tap_b <= CODE_W'(RST_TAP);
      sel   <= 1'b0;
      cnt   <= '0;
    end else if (sample_valid) begin
      if (sel) tap_a <= alt_nxt;
      else     tap_b <= alt_nxt;
      sel <= sel_nxt;
      cnt <= cnt_nxt;
    end
  end

  // R5
  func_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(func_code));

  // R6
  swap_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (func_code == $past(alt_code)) && (sel != $past(sel)));

  // R5
  alt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !swap) |=> ((alt_code == $past(alt_code)) ||
                                 (alt_code == $past(alt_code) + ONE) ||
                                 (alt_code == $past(alt_code) - ONE)));

  // R6
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(tap_a) && $stable(tap_b) && $stable(sel));

endmodule

// File: rtl/eye_vref_trainer.sv
module eye_vref_trainer #(
  parameter int VREF_W   = 5,
  parameter int VREF_MAX = 30,
  parameter int VREF_RST = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              up,
  output logic [VREF_W-1:0] code
);

  localparam logic [VREF_W-1:0] TOP = VREF_W'(VREF_MAX);

  logic [VREF_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code;
    if (up) begin
      if (code < TOP) code_nxt = code + VREF_W'(1);
    end else begin
      if (code != '0) code_nxt = code - VREF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= VREF_W'(VREF_RST);
    else if (step) code <= code_nxt;
  end

  // R7
  vref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code <= TOP);

  // R7
  vref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(code));

endmodule

// File: rtl/eye_trk_lane.sv
module eye_trk_lane
  import eye_trk_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int MATCH_N  = 8,
  parameter int VREF_W   = 5,
  parameter int VREF_MAX = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_valid,
  input  logic              setup_err,
  input  logic              hold_err,
  input  logic              sample_valid,
  input  logic              alt_match,
  input  logic              vref_step,
  input  logic              vref_up,
  input  logic [2:0]        rd_addr,
  output logic [CODE_W-1:0] setup_code,
  output logic [CODE_W-1:0] hold_code,
  output logic [CODE_W-1:0] tap_a_code,
  output logic [CODE_W-1:0] tap_b_code,
  output logic              data_sel,
  output logic [VREF_W-1:0] vref_code,
  output logic [CODE_W-1:0] eye_width,
  output logic [(CODE_W > VREF_W ? CODE_W : VREF_W)-1:0] rd_data
);

  localparam int LINE_LEN = 1 << CODE_W;
  localparam int RST_HOLD = LINE_LEN / 2;
  localparam int RST_TAP  = LINE_LEN / 4;
  localparam int VREF_RST = VREF_MAX / 2;
  localparam int RD_W     = (CODE_W > VREF_W) ? CODE_W : VREF_W;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [CODE_W-1:0] centre, func_code, alt_code;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1] & rst_n;

  eye_edge_probe #(.CODE_W(CODE_W), .LEADING(1'b1), .RST_CODE(0)) u_setup (
    .clk(clk), .rst_n(rst_q_n), .upd(edge_valid), .err(setup_err), .code(setup_code)
  );

  eye_edge_probe #(.CODE_W(CODE_W), .LEADING(1'b0), .RST_CODE(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_q_n), .upd(edge_valid), .err(hold_err), .code(hold_code)
  );

  assign eye_width = hold_code - setup_code;
  assign centre    = setup_code + (eye_width >> 1);

  eye_tap_pingpong #(.CODE_W(CODE_W), .MATCH_N(MATCH_N), .RST_TAP(RST_TAP)) u_taps (
    .clk(clk), .rst_n(rst_q_n), .sample_valid(sample_valid), .alt_match(alt_match),
    .centre(centre), .tap_a(tap_a_code), .tap_b(tap_b_code), .sel(data_sel),
    .func_code(func_code), .alt_code(alt_code)
  );

  eye_vref_trainer #(.VREF_W(VREF_W), .VREF_MAX(VREF_MAX), .VREF_RST(VREF_RST)) u_vref (
    .clk(clk), .rst_n(rst_q_n), .step(vref_step), .up(vref_up), .code(vref_code)
  );

  always_comb begin
    case (rd_sel_e'(rd_addr))
      RD_SETUP:  rd_data = RD_W'(setup_code);
      RD_HOLD:   rd_data = RD_W'(hold_code);
      RD_FUNC:   rd_data = RD_W'(func_code);
      RD_ALT:    rd_data = RD_W'(alt_code);
      RD_WIDTH:  rd_data = RD_W'(eye_width);
      RD_CENTRE: rd_data = RD_W'(centre);
      RD_VREF:   rd_data = RD_W'(vref_code);
      default:   rd_data = RD_W'(data_sel);
    endcase
  end

  // R4
  width_span_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (edge_valid && ($past(edge_valid) || 1'b1)) |=>
      ((eye_width == $past(eye_width)) ||
       (eye_width == $past(eye_width) + CODE_W'(2)) ||
       (eye_width == $past(eye_width) - CODE_W'(2))));

endmodule

// File: tb/tb_eye_trk_lane.sv
module tb_eye_trk_lane;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       edge_valid, setup_err, hold_err;
  logic       sample_valid, alt_match, vref_step, vref_up;
  logic [2:0] rd_addr;
  logic [5:0] setup_code, hold_code, tap_a_code, tap_b_code, eye_width, rd_data;
  logic       data_sel;
  logic [4:0] vref_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  eye_trk_lane dut (
    .clk(clk), .rst_n(rst_n), .edge_valid(edge_valid), .setup_err(setup_err),
    .hold_err(hold_err), .sample_valid(sample_valid), .alt_match(alt_match),
    .vref_step(vref_step), .vref_up(vref_up), .rd_addr(rd_addr),
    .setup_code(setup_code), .hold_code(hold_code), .tap_a_code(tap_a_code),
    .tap_b_code(tap_b_code), .data_sel(data_sel), .vref_code(vref_code),
    .eye_width(eye_width), .rd_data(rd_data)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_chk(string req, int addr, int exp);
    rd_addr = 3'(addr);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    check("R1 setup in reset", int'(setup_code), 0);
    rst_n = 1'b1;
    cycles(4);
    check("R1 setup", int'(setup_code), 0);
    check("R1 hold", int'(hold_code), 32);
    check("R1 tap a", int'(tap_a_code), 16);
    check("R1 tap b", int'(tap_b_code), 16);
    check("R1 sel", int'(data_sel), 0);
    check("R1 width", int'(eye_width), 32);
    check("R1 vref", int'(vref_code), 15);
    read_chk("R8 width read", 4, 32);
  endtask

  task automatic t_edges;
    setup_err = 1'b1; hold_err = 1'b1;
    cycles(3);
    check("R2 no strobe setup", int'(setup_code), 0);
    check("R2 no strobe hold", int'(hold_code), 32);
    edge_valid = 1'b1; setup_err = 1'b1; hold_err = 1'b0;
    cycles(4);
    edge_valid = 1'b0;
    check("R2 setup up", int'(setup_code), 4);
    check("R2 hold up", int'(hold_code), 36);
    check("R4 width", int'(eye_width), 32);
    read_chk("R4 centre", 5, 20);
    check("R5 taps idle", int'(tap_b_code), 16);
  endtask

  task automatic t_track;
    sample_valid = 1'b1; alt_match = 1'b0;
    cycles(2);
    check("R5 alt walk", int'(tap_b_code), 18);
    check("R5 func hold", int'(tap_a_code), 16);
    cycles(2);
    check("R5 alt at centre", int'(tap_b_code), 20);
    cycles(2);
    check("R5 alt stays", int'(tap_b_code), 20);
    sample_valid = 1'b0;
  endtask

  task automatic t_swap;
    sample_valid = 1'b1; alt_match = 1'b1;
    cycles(7);
    check("R6 no early swap", int'(data_sel), 0);
    alt_match = 1'b0;
    cycles(1);
    alt_match = 1'b1;
    cycles(7);
    check("R6 run restarted", int'(data_sel), 0);
    cycles(1);
    check("R6 swap on 8th", int'(data_sel), 1);
    read_chk("R6 func after swap", 2, 20);
    read_chk("R6 alt after swap", 3, 16);
    alt_match = 1'b0;
    cycles(4);
    check("R5 new alt walk", int'(tap_a_code), 20);
    alt_match = 1'b1;
    cycles(4);
    sample_valid = 1'b0;
    cycles(3);
    check("R6 idle keeps sel", int'(data_sel), 1);
    sample_valid = 1'b1;
    cycles(3);
    check("R6 idle not counted", int'(data_sel), 1);
    cycles(1);
    check("R6 second swap", int'(data_sel), 0);
    sample_valid = 1'b0; alt_match = 1'b0;
  endtask

  task automatic t_wrap;
    edge_valid = 1'b1; setup_err = 1'b0; hold_err = 1'b1;
    cycles(24);
    edge_valid = 1'b0;
    check("R3 setup wraps down", int'(setup_code), 44);
    check("R2 hold down", int'(hold_code), 12);
    read_chk("R4 centre wrapped", 5, 60);
    sample_valid = 1'b1;
    cycles(21);
    check("R3 alt wraps through zero", int'(tap_b_code), 63);
    cycles(3);
    check("R5 short way to centre", int'(tap_b_code), 60);
    cycles(1);
    check("R5 holds at centre", int'(tap_b_code), 60);
    check("R5 func unchanged", int'(tap_a_code), 20);
    sample_valid = 1'b0;
    edge_valid = 1'b1; setup_err = 1'b1; hold_err = 1'b0;
    cycles(32);
    edge_valid = 1'b0;
    check("R3 setup wraps up", int'(setup_code), 12);
    read_chk("R4 centre tie", 5, 28);
    sample_valid = 1'b1;
    cycles(1);
    sample_valid = 1'b0;
    check("R5 tie steps down", int'(tap_b_code), 59);
  endtask

  task automatic t_vref;
    vref_step = 1'b0; vref_up = 1'b1;
    cycles(3);
    check("R7 no step", int'(vref_code), 15);
    vref_step = 1'b1;
    cycles(20);
    check("R7 clamp high", int'(vref_code), 30);
    vref_up = 1'b0;
    cycles(40);
    check("R7 clamp low", int'(vref_code), 0);
    vref_up = 1'b1;
    cycles(1);
    vref_step = 1'b0;
    check("R7 one up", int'(vref_code), 1);
  endtask

  task automatic t_read;
    read_chk("R8 setup", 0, 12);
    read_chk("R8 hold", 1, 44);
    read_chk("R8 func", 2, 20);
    read_chk("R8 alt", 3, 59);
    read_chk("R8 width", 4, 32);
    read_chk("R8 centre", 5, 28);
    read_chk("R8 vref", 6, 1);
    read_chk("R8 sel", 7, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    edge_valid = 1'b0; setup_err = 1'b0; hold_err = 1'b0;
    sample_valid = 1'b0; alt_match = 1'b0;
    vref_step = 1'b0; vref_up = 1'b0; rd_addr = 3'd0;
    cycles(3);
    t_reset;
    t_edges;
    t_track;
    t_swap;
    t_wrap;
    t_vref;
    t_read;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule